// File: doc/BRIEF.md
# Cache Line State and Write-Policy Controller

This controller sits beside a set-associative cache and decides, for every access, what happens to the addressed line and to the external bus. A requester presents an address, a read/write flag and a two-bit region mode. The tag-lookup logic then supplies a hit flag, the hit way, a replacement candidate and that candidate's stored tag. From these the controller keeps the per-line valid (V) and modified (M) bits. It pulses a line-update strobe toward the data array and a tag-write strobe toward the tag array. It also drives a single request/acknowledge bus for line fills, single external reads and writes, and victim pushes.

Regions come in three kinds. Copyback writes stay in the cache. Write-through writes always reach memory. Cache-inhibited accesses never touch the cache. A victim that holds modified data is copied into a one-line push buffer before it is invalidated. Its write to memory is sent only after the replacement line has been read. While the push is still pending, a second dirty eviction waits in a drain state. A `busy` output holds the requester off for the whole access.

Top module: `cache_line_policy`

## Requirements
- R1: A read hit (mode 00 or 01) completes with `busy` high for exactly one cycle, leaves V and M of every line unchanged and produces no bus transfer and no `line_we`.
- R2: A write hit in a write-through region (mode 01) pulses `line_we` for the hit way and issues exactly one bus WRITE (command 01) at the request address, and M of that line stays 0.
- R3: A write hit in a copyback region (mode 00) pulses `line_we` for the hit way, issues no bus transfer, leaves V=1 and sets M=1, with `busy` high for one cycle.
- R4: A write miss in a write-through region issues one bus WRITE at the request address, with no FILL, no `tag_we`, and no change to the V and M bits of the offered victim way.
- R5: A write miss in a copyback region fills the line (command 00), writes the tag, pulses `line_we` for the victim way, and leaves that way with V=1 and M=1; no bus WRITE is issued.
- R6: A read miss issues a FILL at the line-aligned address (low 4 bits zero) and then writes address bits [31:11] as the tag into the victim way of set address[10:4], leaving V=1 and M=0.
- R7: The victim way never reads as valid while its fill is outstanding; V is set only in the cycle the fill is acknowledged.
- R8: Allocating over a clean victim invalidates it and issues no PUSH.
- R9: Allocating over a modified victim issues the new line's FILL first and afterwards a PUSH (command 10) at {victim tag, set, 4'b0}.
- R10: A write in an inhibited region (mode 1x) issues one bus WRITE at the request address, produces no `line_we` even when lookup reports a hit, and changes no V or M bit.
- R11: A read in an inhibited region issues one bus READ (command 11) at the request address and no FILL or `tag_we`.
- R12: The push buffer holds one line. A dirty eviction that finds a push pending waits until that push is acknowledged, so the bus order is FILL, PUSH, FILL, PUSH.
- R13: `busy` is low after reset and while idle, and stays high from the cycle after a request is accepted until the access completes.
- R14: Once `bus_req` is raised, it, `bus_cmd` and `bus_addr` stay unchanged until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, accepted while `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 00 copyback, 01 write-through, 1x inhibited |
| req_addr | input | ADDR_W | Byte address of the access |
| busy | output | 1 | Access in progress |
| lk_hit | input | 1 | Tag lookup hit, valid in the cycle after acceptance |
| lk_hit_way | input | WAY_W | Way that hit |
| lk_victim_way | input | WAY_W | Replacement candidate |
| lk_victim_tag | input | TAG_W | Stored tag of the candidate |
| probe_set | input | SET_W | Set whose state bits are shown |
| probe_v | output | WAYS | Valid bits of the probed set |
| probe_m | output | WAYS | Modified bits of the probed set |
| line_we | output | 1 | Write access data into a line |
| line_way | output | WAY_W | Way for `line_we` |
| tag_we | output | 1 | Write a new tag |
| tag_way | output | WAY_W | Way for `tag_we` |
| tag_set | output | SET_W | Set for `tag_we` |
| tag_value | output | TAG_W | Tag to store |
| bus_req | output | 1 | Bus transfer request |
| bus_cmd | output | 2 | 00 FILL, 01 WRITE, 10 PUSH, 11 READ |
| bus_addr | output | ADDR_W | Transfer address |
| bus_ack | input | 1 | One-cycle completion of the current transfer |

## Verification
A hit resolves in the lookup cycle. `line_we` is high during that cycle, and the V/M change appears on the probe after the next rising edge, so `busy` lasts one cycle. Fill results (`tag_we`, `line_we` on a copyback miss, V set) coincide with the acknowledge cycle. A push starts only once the controller is idle again, or while it is draining, so it always follows the fill that caused it. The bench's bus model raises `bus_ack` at a falling edge and logs the transfer at that moment. Every observation is taken 1 to 2 ns after a falling edge, when all of that half-cycle's values are settled. Transfer order and V/M values are read only once `busy` has dropped or the bus has gone quiet.

// File: rtl/clp_pkg.sv
package clp_pkg;

  localparam logic [1:0] MODE_CB = 2'b00;
  localparam logic [1:0] MODE_WT = 2'b01;

  localparam logic [1:0] CMD_FILL  = 2'b00;
  localparam logic [1:0] CMD_WRITE = 2'b01;
  localparam logic [1:0] CMD_PUSH  = 2'b10;
  localparam logic [1:0] CMD_READ  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_DRAIN, ST_PUSHCAP, ST_FILL, ST_EXT
  } state_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_CB_HIT, ACT_WT_HIT, ACT_EXT_WR, ACT_EXT_RD, ACT_ALLOC
  } act_e;

  // Policy table: region mode, direction and hit pick the action.
  function automatic act_e classify(input logic wr, input logic [1:0] mode,
                                    input logic hit);
    if (mode[1])                return wr ? ACT_EXT_WR : ACT_EXT_RD;
    if (hit && !wr)             return ACT_NONE;
    if (hit)                    return (mode == MODE_WT) ? ACT_WT_HIT : ACT_CB_HIT;
    if (wr && mode == MODE_WT)  return ACT_EXT_WR;
    return ACT_ALLOC;
  endfunction

endpackage

// File: rtl/clp_line_state.sv
module clp_line_state #(
  parameter int WAYS  = 4,
  parameter int SET_W = 7,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_fill,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic             wr_v,
  input  logic             wr_m,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAY_W-1:0] rd_way,
  output logic             rd_v,
  output logic             rd_m,
  input  logic [SET_W-1:0] probe_set,
  output logic [WAYS-1:0]  probe_v,
  output logic [WAYS-1:0]  probe_m
);

  logic [WAYS-1:0] v_q [SETS];
  logic [WAYS-1:0] m_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        m_q[s] <= '0;
      end
    end else if (wr_en) begin
      v_q[wr_set][wr_way] <= wr_v;
      m_q[wr_set][wr_way] <= wr_m;
    end
  end

  assign rd_v    = v_q[rd_set][rd_way];
  assign rd_m    = m_q[rd_set][rd_way];
  assign probe_v = v_q[probe_set];
  assign probe_m = m_q[probe_set];

  // R7: an invalid line turns valid only through a completed fill
  assert_valid_needs_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_v && !v_q[wr_set][wr_way]) |-> wr_fill)
    else $error("line became valid without a fill");

  // R3: modified is never recorded on an invalid line
  assert_m_implies_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_m) |-> wr_v)
    else $error("modified set on invalid line");

endmodule

// File: rtl/clp_push_buf.sv
module clp_push_buf #(
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              bus_free,
  input  logic              bus_ack,
  output logic              pend,
  output logic              go,
  output logic [ADDR_W-1:0] push_addr
);

  logic push_done;
  assign push_done = go && bus_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      go        <= 1'b0;
      push_addr <= '0;
    end else begin
      if (cap_en) begin
        pend      <= 1'b1;
        push_addr <= cap_addr;
      end else if (push_done) begin
        pend <= 1'b0;
      end
      if (push_done)                   go <= 1'b0;
      else if (pend && !go && bus_free) go <= 1'b1;
    end
  end

  // R12: single-line buffer is never overwritten while occupied
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> !pend)
    else $error("push buffer overwritten");

  // R9: a push only runs while a line is held
  assert_go_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> pend)
    else $error("push without content");

endmodule

// File: rtl/cache_line_policy.sv
module cache_line_policy import clp_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int TAG_LO  = 11,
  parameter int LINE_LO = 4,
  parameter int WAYS    = 4,
  localparam int SET_W = TAG_LO - LINE_LO,
  localparam int TAG_W = ADDR_W - TAG_LO,
  localparam int WAY_W = $clog2(WAYS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  input  logic              lk_hit,
  input  logic [WAY_W-1:0]  lk_hit_way,
  input  logic [WAY_W-1:0]  lk_victim_way,
  input  logic [TAG_W-1:0]  lk_victim_tag,
  input  logic [SET_W-1:0]  probe_set,
  output logic [WAYS-1:0]   probe_v,
  output logic [WAYS-1:0]   probe_m,
  output logic              line_we,
  output logic [WAY_W-1:0]  line_way,
  output logic              tag_we,
  output logic [WAY_W-1:0]  tag_way,
  output logic [SET_W-1:0]  tag_set,
  output logic [TAG_W-1:0]  tag_value,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack
);

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:LINE_LO], {LINE_LO{1'b0}}};
  endfunction

  state_e             state;
  logic [ADDR_W-1:0]  r_addr;
  logic               r_write;
  logic [1:0]         r_mode;
  logic [WAY_W-1:0]   r_vic_way;
  logic [TAG_W-1:0]   r_vic_tag;

  // named internal events
  act_e               act_now;
  logic [SET_W-1:0]   set_idx;
  logic               fsm_owns, fill_done, ext_done, pushcap_ev, rd_hit_ev;
  logic               vic_dirty, vic_v, vic_m;
  logic               ls_wr_en, ls_wr_v, ls_wr_m;
  logic [WAY_W-1:0]   ls_wr_way, ls_rd_way;
  logic               pb_pend, pb_go;
  logic [ADDR_W-1:0]  pb_addr;

  assign set_idx    = r_addr[LINE_LO +: SET_W];
  assign act_now    = classify(r_write, r_mode, lk_hit);
  assign fsm_owns   = (state == ST_FILL || state == ST_EXT) && !pb_go;
  assign fill_done  = fsm_owns && state == ST_FILL && bus_ack;
  assign ext_done   = fsm_owns && state == ST_EXT && bus_ack;
  assign pushcap_ev = (state == ST_PUSHCAP);
  assign rd_hit_ev  = (state == ST_LOOKUP) && (act_now == ACT_NONE);
  assign ls_rd_way  = (state == ST_LOOKUP) ? lk_victim_way : r_vic_way;
  assign vic_dirty  = vic_v && vic_m;
  assign busy       = (state != ST_IDLE);

  always_comb begin
    ls_wr_en  = 1'b0;
    ls_wr_v   = 1'b0;
    ls_wr_m   = 1'b0;
    ls_wr_way = r_vic_way;
    line_we   = 1'b0;
    line_way  = r_vic_way;
    if (state == ST_LOOKUP) begin
      if (act_now == ACT_CB_HIT) begin
        ls_wr_en = 1'b1; ls_wr_v = 1'b1; ls_wr_m = 1'b1; ls_wr_way = lk_hit_way;
      end else if (act_now == ACT_ALLOC && !vic_dirty) begin
        ls_wr_en = 1'b1; ls_wr_way = lk_victim_way;
      end
      if (act_now == ACT_CB_HIT || act_now == ACT_WT_HIT) begin
        line_we = 1'b1; line_way = lk_hit_way;
      end
    end else if (pushcap_ev) begin
      ls_wr_en = 1'b1;
    end else if (fill_done) begin
      ls_wr_en = 1'b1; ls_wr_v = 1'b1; ls_wr_m = r_write;
      line_we  = r_write;
    end
  end

  assign tag_we    = fill_done;
  assign tag_way   = r_vic_way;
  assign tag_set   = set_idx;
  assign tag_value = r_addr[ADDR_W-1:TAG_LO];

  always_comb begin
    bus_req  = pb_go || state == ST_FILL || state == ST_EXT;
    bus_cmd  = CMD_FILL;
    bus_addr = line_base(r_addr);
    if (pb_go) begin
      bus_cmd  = CMD_PUSH;
      bus_addr = pb_addr;
    end else if (state == ST_EXT) begin
      bus_cmd  = r_write ? CMD_WRITE : CMD_READ;
      bus_addr = r_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_addr    <= '0;
      r_write   <= 1'b0;
      r_mode    <= MODE_CB;
      r_vic_way <= '0;
      r_vic_tag <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          r_addr  <= req_addr;
          r_write <= req_write;
          r_mode  <= req_mode;
          state   <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          r_vic_way <= lk_victim_way;
          r_vic_tag <= lk_victim_tag;
          case (act_now)
            ACT_WT_HIT, ACT_EXT_WR, ACT_EXT_RD: state <= ST_EXT;
            ACT_ALLOC: begin
              if (!vic_dirty)   state <= ST_FILL;
              else if (pb_pend) state <= ST_DRAIN;
              else              state <= ST_PUSHCAP;
            end
            default: state <= ST_IDLE;
          endcase
        end
        ST_DRAIN:   if (!pb_pend) state <= ST_PUSHCAP;
        ST_PUSHCAP: state <= ST_FILL;
        ST_FILL:    if (fill_done) state <= ST_IDLE;
        ST_EXT:     if (ext_done) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  clp_line_state #(.WAYS(WAYS), .SET_W(SET_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ls_wr_en), .wr_fill(fill_done), .wr_set(set_idx), .wr_way(ls_wr_way),
    .wr_v(ls_wr_v), .wr_m(ls_wr_m),
    .rd_set(set_idx), .rd_way(ls_rd_way), .rd_v(vic_v), .rd_m(vic_m),
    .probe_set(probe_set), .probe_v(probe_v), .probe_m(probe_m)
  );

  clp_push_buf #(.ADDR_W(ADDR_W)) u_push (
    .clk(clk), .rst_n(rst_n),
    .cap_en(pushcap_ev), .cap_addr({r_vic_tag, set_idx, {LINE_LO{1'b0}}}),
    .bus_free(state == ST_IDLE || state == ST_DRAIN), .bus_ack(bus_ack),
    .pend(pb_pend), .go(pb_go), .push_addr(pb_addr)
  );

  // R1: a read hit touches no line state and finishes at once
  assert_read_hit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_ev |-> (!ls_wr_en && !line_we))
    else $error("read hit changed line state");
  assert_read_hit_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_ev |=> state == ST_IDLE)
    else $error("read hit did not finish");

  // R3: modified is only ever recorded for copyback writes
  assert_m_copyback_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_wr_en && ls_wr_m) |-> (r_mode == MODE_CB && r_write))
    else $error("modified set outside copyback write");

  // R5: no memory write is ever issued for a copyback access
  assert_no_cb_memwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == CMD_WRITE) |-> r_mode != MODE_CB)
    else $error("copyback access wrote memory");

  // R6: tag write coincides with the fill acknowledge
  assert_tag_on_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> (bus_ack && bus_cmd == CMD_FILL))
    else $error("tag written outside fill completion");

  // R14: request, command and address held until acknowledged
  assert_bus_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)))
    else $error("bus request changed before ack");

  // R13: busy while an access is outstanding on the bus
  assert_busy_on_fill_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd != CMD_PUSH) |-> busy)
    else $error("bus access while idle");

endmodule

// File: tb/cache_line_policy_test.sv
`timescale 1ns/1ps
module cache_line_policy_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_mode = 2'b00;
  logic [31:0] req_addr = '0;
  logic        busy;
  logic        lk_hit = 1'b0;
  logic [1:0]  lk_hit_way = '0, lk_victim_way = '0;
  logic [20:0] lk_victim_tag = '0;
  logic [6:0]  probe_set = '0;
  logic [3:0]  probe_v, probe_m;
  logic        line_we, tag_we;
  logic [1:0]  line_way, tag_way;
  logic [6:0]  tag_set;
  logic [20:0] tag_value;
  logic        bus_req;
  logic [1:0]  bus_cmd;
  logic [31:0] bus_addr;
  logic        bus_ack = 1'b0;

  always #2.5 clk = ~clk;

  cache_line_policy uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .req_addr(req_addr), .busy(busy), .lk_hit(lk_hit),
    .lk_hit_way(lk_hit_way), .lk_victim_way(lk_victim_way), .lk_victim_tag(lk_victim_tag),
    .probe_set(probe_set), .probe_v(probe_v), .probe_m(probe_m),
    .line_we(line_we), .line_way(line_way), .tag_we(tag_we), .tag_way(tag_way),
    .tag_set(tag_set), .tag_value(tag_value), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_ack(bus_ack)
  );

  int nchk = 0, nbad = 0;
  int ack_lat = 0, wait_cnt = 0;
  logic [1:0]  lcmd [32];
  logic [31:0] laddr [32];
  int nlog = 0, tag_cnt = 0, line_cnt = 0, busy_cnt = 0, hold_bad = 0;
  logic [20:0] tag_val_l; logic [1:0] tag_way_l, line_way_l; logic [6:0] tag_set_l;
  bit hold_prev = 0; logic [1:0] hold_cmd; logic [31:0] hold_addr;
  bit r7_seen = 0;

  // bus responder: ack after ack_lat waiting cycles, log at ack time
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (wait_cnt >= ack_lat) begin
        bus_ack = 1'b1; wait_cnt = 0;
        if (nlog < 32) begin lcmd[nlog] = bus_cmd; laddr[nlog] = bus_addr; end
        nlog++;
      end else wait_cnt++;
    end
  end

  // event monitor, 1 ns after the falling edge
  always begin
    @(negedge clk); #1;
    if (tag_we) begin tag_cnt++; tag_val_l = tag_value; tag_way_l = tag_way; tag_set_l = tag_set; end
    if (line_we) begin line_cnt++; line_way_l = line_way; end
    if (busy) busy_cnt++;
    if (hold_prev && (!bus_req || bus_cmd != hold_cmd || bus_addr != hold_addr)) hold_bad++;
    hold_prev = bus_req && !bus_ack; hold_cmd = bus_cmd; hold_addr = bus_addr;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [20:0] tg, input int st, input int off);
    return {tg, st[6:0], off[3:0]};
  endfunction

  task automatic clear_logs();
    nlog = 0; tag_cnt = 0; line_cnt = 0; busy_cnt = 0;
  endtask

  task automatic peek(input int st, input int way, output bit v, output bit m);
    probe_set = st[6:0]; #1;
    v = probe_v[way]; m = probe_m[way];
  endtask

  task automatic do_access(input bit wr, input logic [1:0] mode, input logic [31:0] addr,
                           input bit hit, input int hway, input int vway, input logic [20:0] vtag);
    @(negedge clk);
    req_write = wr; req_mode = mode; req_addr = addr; lk_hit = hit;
    lk_hit_way = hway[1:0]; lk_victim_way = vway[1:0]; lk_victim_tag = vtag;
    probe_set = addr[10:4]; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0; r7_seen = 0;
    #2;
    while (busy) begin
      if (bus_req && bus_cmd == 2'b00 && !bus_ack && probe_v[vway]) r7_seen = 1;
      @(negedge clk); #2;
    end
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    bit v, m;
    chk(busy == 1'b0, "R13 busy after reset", busy, 0);
    chk(bus_req == 1'b0, "R13 bus idle after reset", bus_req, 0);
    peek(0, 0, v, m);
    chk(probe_v == 4'h0 && probe_m == 4'h0, "R13 state bits cleared", {probe_v, probe_m}, 0);
  endtask

  task automatic t_read_miss();
    bit v, m; logic [31:0] a = mk(21'h1ABCD, 3, 8);
    ack_lat = 3; clear_logs();
    do_access(0, 2'b01, a, 0, 0, 2, 21'h0);
    settle();
    chk(nlog == 1 && lcmd[0] == 2'b00, "R6 single fill", {nlog[7:0], lcmd[0]}, {8'd1, 2'b00});
    chk(laddr[0] == {a[31:4], 4'h0}, "R6 fill line address", laddr[0], {a[31:4], 4'h0});
    chk(tag_cnt == 1 && tag_val_l == 21'h1ABCD && tag_way_l == 2 && tag_set_l == 3,
        "R6 tag write", {tag_cnt[7:0], tag_val_l, tag_way_l, tag_set_l}, {8'd1, 21'h1ABCD, 2'd2, 7'd3});
    peek(3, 2, v, m);
    chk(v && !m, "R6 V=1 M=0 after read fill", {v, m}, 2'b10);
    chk(!r7_seen, "R7 victim invalid during fill", r7_seen, 0);
    chk(line_cnt == 0, "R6 no line write on read fill", line_cnt, 0);
  endtask

  task automatic t_read_hit();
    bit v, m; clear_logs();
    do_access(0, 2'b00, mk(21'h1ABCD, 3, 4), 1, 2, 0, 21'h0);
    chk(busy_cnt == 1, "R1 busy one cycle", busy_cnt, 1);
    settle();
    chk(nlog == 0 && line_cnt == 0, "R1 no bus or line write", {nlog[7:0], line_cnt[7:0]}, 0);
    peek(3, 2, v, m);
    chk(v && !m, "R1 V/M unchanged", {v, m}, 2'b10);
  endtask

  task automatic t_wt_hit();
    bit v, m; logic [31:0] a = mk(21'h1ABCD, 3, 6);
    clear_logs();
    do_access(1, 2'b01, a, 1, 2, 0, 21'h0);
    settle();
    chk(nlog == 1 && lcmd[0] == 2'b01 && laddr[0] == a, "R2 one external write",
        {nlog[7:0], lcmd[0], laddr[0]}, {8'd1, 2'b01, a});
    chk(line_cnt == 1 && line_way_l == 2, "R2 line updated", {line_cnt[7:0], line_way_l}, {8'd1, 2'd2});
    peek(3, 2, v, m);
    chk(v && !m, "R2 M stays clear", {v, m}, 2'b10);
  endtask

  task automatic t_cb_hit();
    bit v, m; clear_logs();
    do_access(1, 2'b00, mk(21'h1ABCD, 3, 2), 1, 2, 0, 21'h0);
    chk(busy_cnt == 1, "R3 busy one cycle", busy_cnt, 1);
    settle();
    chk(nlog == 0, "R3 no bus transfer", nlog, 0);
    chk(line_cnt == 1 && line_way_l == 2, "R3 line updated", {line_cnt[7:0], line_way_l}, {8'd1, 2'd2});
    peek(3, 2, v, m);
    chk(v && m, "R3 V=1 M=1", {v, m}, 2'b11);
  endtask

  task automatic t_wt_miss();
    bit v, m; logic [31:0] a = mk(21'h00777, 3, 0);
    clear_logs();
    do_access(1, 2'b01, a, 0, 0, 2, 21'h1ABCD);
    settle();
    chk(nlog == 1 && lcmd[0] == 2'b01 && laddr[0] == a, "R4 write only, no fill",
        {nlog[7:0], lcmd[0], laddr[0]}, {8'd1, 2'b01, a});
    chk(tag_cnt == 0, "R4 no tag write", tag_cnt, 0);
    peek(3, 2, v, m);
    chk(v && m, "R4 victim V/M untouched", {v, m}, 2'b11);
  endtask

  task automatic t_cb_miss();
    bit v, m; logic [31:0] a = mk(21'h02222, 7, 12);
    ack_lat = 2; clear_logs();
    do_access(1, 2'b00, a, 0, 0, 1, 21'h0);
    settle();
    chk(nlog == 1 && lcmd[0] == 2'b00, "R5 fill only, no memory write", {nlog[7:0], lcmd[0]}, {8'd1, 2'b00});
    chk(tag_cnt == 1 && line_cnt == 1 && line_way_l == 1, "R5 tag and line write",
        {tag_cnt[7:0], line_cnt[7:0], line_way_l}, {8'd1, 8'd1, 2'd1});
    peek(7, 1, v, m);
    chk(v && m, "R5 V=1 M=1", {v, m}, 2'b11);
    chk(!r7_seen, "R7 victim invalid during fill", r7_seen, 0);
  endtask

  task automatic t_inhibit();
    bit v, m; logic [31:0] a = mk(21'h00555, 3, 9);
    clear_logs();
    do_access(1, 2'b10, a, 1, 2, 2, 21'h1ABCD);
    settle();
    chk(nlog == 1 && lcmd[0] == 2'b01 && laddr[0] == a, "R10 inhibited write",
        {nlog[7:0], lcmd[0], laddr[0]}, {8'd1, 2'b01, a});
    chk(line_cnt == 0, "R10 no line write", line_cnt, 0);
    peek(3, 2, v, m);
    chk(v && m, "R10 state unchanged", {v, m}, 2'b11);
    clear_logs();
    do_access(0, 2'b11, a, 0, 0, 2, 21'h1ABCD);
    settle();
    chk(nlog == 1 && lcmd[0] == 2'b11 && laddr[0] == a, "R11 inhibited read",
        {nlog[7:0], lcmd[0], laddr[0]}, {8'd1, 2'b11, a});
    chk(tag_cnt == 0, "R11 no tag write", tag_cnt, 0);
  endtask

  task automatic t_dirty_then_clean();
    bit v, m; logic [31:0] a = mk(21'h03333, 3, 0);
    ack_lat = 4; clear_logs();
    do_access(0, 2'b00, a, 0, 0, 2, 21'h1ABCD);
    settle();
    chk(nlog == 2 && lcmd[0] == 2'b00 && lcmd[1] == 2'b10, "R9 fill then push",
        {nlog[7:0], lcmd[0], lcmd[1]}, {8'd2, 2'b00, 2'b10});
    chk(laddr[1] == mk(21'h1ABCD, 3, 0), "R9 push address", laddr[1], mk(21'h1ABCD, 3, 0));
    peek(3, 2, v, m);
    chk(v && !m, "R9 new line clean", {v, m}, 2'b10);
    clear_logs();
    do_access(0, 2'b00, mk(21'h04444, 3, 0), 0, 0, 2, 21'h03333);
    settle();
    chk(nlog == 1 && lcmd[0] == 2'b00, "R8 clean victim not pushed", {nlog[7:0], lcmd[0]}, {8'd1, 2'b00});
  endtask

  task automatic t_back_to_back();
    ack_lat = 1;
    do_access(1, 2'b00, mk(21'h00A09, 9, 0), 0, 0, 0, 21'h0);
    do_access(1, 2'b00, mk(21'h00A10, 10, 0), 0, 0, 0, 21'h0);
    settle();
    ack_lat = 6; clear_logs();
    do_access(0, 2'b00, mk(21'h00B09, 9, 0), 0, 0, 0, 21'h00A09);
    do_access(0, 2'b00, mk(21'h00B10, 10, 0), 0, 0, 0, 21'h00A10);
    settle();
    chk(nlog == 4, "R12 four transfers", nlog, 4);
    chk(lcmd[0] == 2'b00 && lcmd[1] == 2'b10 && lcmd[2] == 2'b00 && lcmd[3] == 2'b10,
        "R12 order fill push fill push", {lcmd[0], lcmd[1], lcmd[2], lcmd[3]}, 8'b00_10_00_10);
    chk(laddr[1] == mk(21'h00A09, 9, 0) && laddr[3] == mk(21'h00A10, 10, 0),
        "R12 push addresses", {laddr[1], laddr[3]}, {mk(21'h00A09, 9, 0), mk(21'h00A10, 10, 0)});
    chk(hold_bad == 0, "R14 bus request held until ack", hold_bad, 0);
  endtask

  initial begin
    #(5 * 150000);
    nchk++; nbad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset();
    t_read_miss();
    t_read_hit();
    t_wt_hit();
    t_cb_hit();
    t_wt_miss();
    t_cb_miss();
    t_inhibit();
    t_dirty_then_clean();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule